// File: doc/BRIEF.md
# Arithmetic right-shift instruction decoder and datapath

The block accepts an instruction stream one byte per clock and recognises the arithmetic-right-shift family. A sequence may start with an address-width override byte (0x52 forces narrow addressing, 0x49 forces wide addressing). It may then carry an index prefix (0xDD selects IX, 0xFD selects IY). It always carries the bit-operation prefix 0xCB. An indexed form adds a displacement byte after 0xCB. The sequence ends with the shift opcode. When a sequence completes, the decoder pulses a done strobe for one cycle. With that pulse it reports the operand selection, the sign-extended displacement, the effective address width and the instruction's cycle count. A sequence that breaks these rules pulses an illegal strobe instead. In both cases the decoder returns to its idle state.

A combinational datapath sits next to the decoder. It shifts an 8-bit operand right by one place and keeps the top bit. It also forms the condition-flag byte. The surrounding core supplies the operand, handles memory and the register file, and sets the current address-width mode bit that applies when no override byte is present.

Top module: `sra_unit`

## Requirements
- R1: `shift_out` equals the operand moved right by one bit, with bit 7 of the operand copied into bit 7 of the result.
- R2: In `flags_out`, bit 0 (carry) holds operand bit 0, bit 7 holds result bit 7, and bit 6 is set when the result is zero. Bit 2 is set when the result has an even number of ones. Bits 5, 4, 3 and 1 are zero.
- R3: The sequence 0xCB then 0b00101rrr, where rrr is not 110, gives done with kind 0 (register), reg equal to rrr, cycles 2, displacement 0 and wide equal to `mode_long`. The register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111.
- R4: The sequence 0xCB 0x2E gives done with kind 1 (memory through HL), reg 110, cycles 5, displacement 0 and wide equal to `mode_long`.
- R5: A leading 0x52 before a memory form reports wide 0, and a leading 0x49 reports wide 1, whatever `mode_long` is. With either override byte, the HL form takes 6 cycles.
- R6: The sequence 0xDD or 0xFD, then 0xCB, then a displacement d, then 0x2E gives done with kind 2 (indexed). `dec_index_iy` is 0 for 0xDD and 1 for 0xFD, the displacement is d sign-extended, and the form takes 7 cycles, or 8 cycles with an override byte in front.
- R7: Done and illegal are single-cycle pulses. Each is registered one clock after the byte that ends the sequence, and the two are never high together.
- R8: The following raise illegal: an unexpected first byte, an override byte followed by anything other than an index prefix or 0xCB, an override byte in front of a register form, a non-0xCB byte after an index prefix, a byte after 0xCB outside the 0b00101xxx group, and any byte other than 0x2E after a displacement. A new sequence then decodes normally.
- R9: Clocks with `byte_valid` low do not advance or disturb a sequence in progress.
- R10: After reset, done and illegal are low and the decoder is idle, so a partly received sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | `byte_in` carries an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| mode_long | input | 1 | Current address-width mode (1 = wide) |
| operand_in | input | 8 | Operand for the shift datapath |
| dec_done | output | 1 | One-cycle pulse: a valid instruction was decoded |
| dec_illegal | output | 1 | One-cycle pulse: the byte sequence was rejected |
| dec_kind | output | 2 | 0 register, 1 memory via HL, 2 indexed |
| dec_reg | output | 3 | rrr field of the final opcode |
| dec_index_iy | output | 1 | Indexed form uses IY (1) or IX (0) |
| dec_disp | output | DISP_W | Sign-extended displacement (0 when not indexed) |
| dec_wide | output | 1 | Effective address width (1 = wide) |
| dec_cycles | output | CYC_W | Cycle count of the decoded instruction |
| shift_out | output | 8 | Shift result |
| flags_out | output | 8 | Condition-flag byte |

## Verification
A corrupted parser state shows up at the ports within one byte. The next byte either raises illegal where done was due, or completes early with the wrong kind or cycle count. The done or illegal pulse in the cycle after the final byte reveals it. A stale override or index latch does not show until the sequence completes: the wide, index or cycle fields then disagree with the bytes that were sent. The datapath is combinational, so a wrong result or flag bit can be seen in the same cycle as the operand, and the bench checks it across all 256 operand values.

// File: rtl/sra_pkg.sv
package sra_pkg;
   typedef enum logic [1:0] {
      OPK_REG = 2'd0,
      OPK_HL  = 2'd1,
      OPK_IDX = 2'd2
   } opnd_kind_t;

   typedef enum logic [2:0] {
      PS_IDLE   = 3'd0,
      PS_SFX    = 3'd1,
      PS_CB     = 3'd2,
      PS_IDX    = 3'd3,
      PS_IDX_CB = 3'd4,
      PS_IDX_D  = 3'd5
   } parse_st_t;

   localparam logic [7:0] BYTE_NARROW = 8'h52;
   localparam logic [7:0] BYTE_WIDE   = 8'h49;
   localparam logic [7:0] BYTE_IX     = 8'hDD;
   localparam logic [7:0] BYTE_IY     = 8'hFD;
   localparam logic [7:0] BYTE_BITOP  = 8'hCB;
   localparam logic [7:0] BYTE_MEMOP  = 8'h2E;
   localparam logic [4:0] SHIFT_GROUP = 5'b00101;
   localparam logic [2:0] RRR_MEM     = 3'b110;
endpackage

// File: rtl/sra_shift_alu.sv
module sra_shift_alu #(
   parameter bit PARITY_CHAIN = 1'b0
) (
   input  logic [7:0] opnd,
   output logic [7:0] res,
   output logic [7:0] flags
);
   logic even_par;

   assign res = {opnd[7], opnd[7:1]};

   generate
      if (PARITY_CHAIN) begin : g_chain
         always_comb begin
            logic acc;
            acc = 1'b1;
            for (int i = 0; i < 8; i++) acc = acc ^ res[i];
            even_par = acc;
         end
      end else begin : g_reduce
         assign even_par = ~(^res);
      end
   endgenerate

   // S Z - H - P/V N C
   assign flags = {res[7], (res == 8'h00), 1'b0, 1'b0, 1'b0, even_par, 1'b0, opnd[0]};
endmodule

// File: rtl/sra_cycle_table.sv
module sra_cycle_table
   import sra_pkg::*;
#(
   parameter int CYC_W       = 4,
   parameter int CYC_REG     = 2,
   parameter int CYC_HL      = 5,
   parameter int CYC_HL_SFX  = 6,
   parameter int CYC_IDX     = 7,
   parameter int CYC_IDX_SFX = 8
) (
   input  opnd_kind_t       kind,
   input  logic             has_sfx,
   output logic [CYC_W-1:0] cycles
);
   localparam int CYC_LIMIT = 1 << CYC_W;

   generate
      if (CYC_REG >= CYC_LIMIT || CYC_HL >= CYC_LIMIT || CYC_HL_SFX >= CYC_LIMIT ||
          CYC_IDX >= CYC_LIMIT || CYC_IDX_SFX >= CYC_LIMIT) begin : g_bad_width
         $error("sra_cycle_table: CYC_W too narrow for cycle counts");
      end
   endgenerate

   always_comb begin
      case (kind)
         OPK_REG: cycles = CYC_W'(CYC_REG);
         OPK_HL:  cycles = has_sfx ? CYC_W'(CYC_HL_SFX) : CYC_W'(CYC_HL);
         OPK_IDX: cycles = has_sfx ? CYC_W'(CYC_IDX_SFX) : CYC_W'(CYC_IDX);
         default: cycles = '0;
      endcase
   end
endmodule

// File: rtl/sra_prefix_parser.sv
module sra_prefix_parser
   import sra_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_valid,
   input  logic [7:0]  byte_in,
   input  logic        mode_long,
   output logic        done,
   output logic        illegal,
   output opnd_kind_t  kind,
   output logic [2:0]  reg_code,
   output logic        use_iy,
   output logic [7:0]  disp8,
   output logic        has_sfx,
   output logic        wide
);
   parse_st_t  st_q, st_d;
   logic       sfx_q, sfxw_q, iy_q;
   logic [7:0] d_q;
   logic       fin, bad;
   opnd_kind_t fin_kind;
   logic       is_sfx, is_idx;

   assign is_sfx = (byte_in == BYTE_NARROW) || (byte_in == BYTE_WIDE);
   assign is_idx = (byte_in == BYTE_IX) || (byte_in == BYTE_IY);

   always_comb begin
      st_d     = st_q;
      fin      = 1'b0;
      bad      = 1'b0;
      fin_kind = OPK_REG;
      if (byte_valid) begin
         case (st_q)
            PS_IDLE: begin
               if (is_sfx)                      st_d = PS_SFX;
               else if (is_idx)                 st_d = PS_IDX;
               else if (byte_in == BYTE_BITOP)  st_d = PS_CB;
               else                             bad  = 1'b1;
            end
            PS_SFX: begin
               if (is_idx)                      st_d = PS_IDX;
               else if (byte_in == BYTE_BITOP)  st_d = PS_CB;
               else                             bad  = 1'b1;
            end
            PS_CB: begin
               if (byte_in[7:3] != SHIFT_GROUP) bad = 1'b1;
               else if (byte_in[2:0] == RRR_MEM) begin
                  fin      = 1'b1;
                  fin_kind = OPK_HL;
               end else if (sfx_q) bad = 1'b1;
               else begin
                  fin      = 1'b1;
                  fin_kind = OPK_REG;
               end
            end
            PS_IDX: begin
               if (byte_in == BYTE_BITOP) st_d = PS_IDX_CB;
               else                       bad  = 1'b1;
            end
            PS_IDX_CB: st_d = PS_IDX_D;
            PS_IDX_D: begin
               if (byte_in == BYTE_MEMOP) begin
                  fin      = 1'b1;
                  fin_kind = OPK_IDX;
               end else bad = 1'b1;
            end
            default: bad = 1'b1;
         endcase
      end
      if (fin || bad) st_d = PS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         sfx_q    <= 1'b0;
         sfxw_q   <= 1'b0;
         iy_q     <= 1'b0;
         d_q      <= '0;
         done     <= 1'b0;
         illegal  <= 1'b0;
         kind     <= OPK_REG;
         reg_code <= '0;
         use_iy   <= 1'b0;
         disp8    <= '0;
         has_sfx  <= 1'b0;
         wide     <= 1'b0;
      end else begin
         st_q    <= st_d;
         done    <= fin;
         illegal <= bad;
         if (byte_valid && st_q == PS_IDLE) begin
            sfx_q  <= is_sfx;
            sfxw_q <= (byte_in == BYTE_WIDE);
         end
         if (byte_valid && (st_q == PS_IDLE || st_q == PS_SFX) && is_idx)
            iy_q <= (byte_in == BYTE_IY);
         if (byte_valid && st_q == PS_IDX_CB)
            d_q <= byte_in;
         if (fin) begin
            kind     <= fin_kind;
            reg_code <= byte_in[2:0];
            use_iy   <= (fin_kind == OPK_IDX) ? iy_q : 1'b0;
            disp8    <= (fin_kind == OPK_IDX) ? d_q : 8'h00;
            has_sfx  <= sfx_q;
            wide     <= sfx_q ? sfxw_q : mode_long;
         end
      end
   end

   p_done_gap_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(done && illegal));
   p_reg_nosfx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind == OPK_REG) |-> !has_sfx);
   p_idle_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || illegal) |-> st_q == PS_IDLE);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> (st_q == $past(st_q)));
endmodule

// File: rtl/sra_unit.sv
module sra_unit
   import sra_pkg::*;
#(
   parameter int DISP_W       = 24,
   parameter int CYC_W        = 4,
   parameter bit PARITY_CHAIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_in,
   input  logic              mode_long,
   input  logic [7:0]        operand_in,
   output logic              dec_done,
   output logic              dec_illegal,
   output logic [1:0]        dec_kind,
   output logic [2:0]        dec_reg,
   output logic              dec_index_iy,
   output logic [DISP_W-1:0] dec_disp,
   output logic              dec_wide,
   output logic [CYC_W-1:0]  dec_cycles,
   output logic [7:0]        shift_out,
   output logic [7:0]        flags_out
);
   localparam int EXT_W = DISP_W - 8;

   opnd_kind_t kind;
   logic [7:0] disp8;
   logic       has_sfx;

   sra_prefix_parser u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_in    (byte_in),
      .mode_long  (mode_long),
      .done       (dec_done),
      .illegal    (dec_illegal),
      .kind       (kind),
      .reg_code   (dec_reg),
      .use_iy     (dec_index_iy),
      .disp8      (disp8),
      .has_sfx    (has_sfx),
      .wide       (dec_wide)
   );

   sra_cycle_table #(.CYC_W(CYC_W)) u_cycles (
      .kind    (kind),
      .has_sfx (has_sfx),
      .cycles  (dec_cycles)
   );

   sra_shift_alu #(.PARITY_CHAIN(PARITY_CHAIN)) u_alu (
      .opnd  (operand_in),
      .res   (shift_out),
      .flags (flags_out)
   );

   assign dec_kind = kind;

   generate
      if (DISP_W < 8) begin : g_bad_disp
         $error("sra_unit: DISP_W must be at least 8");
      end else if (DISP_W == 8) begin : g_disp_same
         assign dec_disp = disp8;
      end else begin : g_disp_ext
         assign dec_disp = {{EXT_W{disp8[7]}}, disp8};
      end
   endgenerate

   p_sign_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_out[7] == operand_in[7] && shift_out[0] == operand_in[1]);
   p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[0] == operand_in[0] && flags_out[1] == 1'b0 && flags_out[4] == 1'b0);
   p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flags_out[6] == (operand_in[7:1] == 7'd0));
   p_cyc_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_done && dec_kind == 2'd0) |-> dec_cycles == CYC_W'(2));
   p_disp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_done && dec_kind != 2'd2) |-> dec_disp == '0);
   p_cyc_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_done && dec_kind == 2'd2) |-> dec_cycles >= CYC_W'(7));
endmodule

// File: tb/sra_unit_test.sv
`timescale 1ns/1ps
module sra_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        mode_long = 1'b0;
   logic [7:0]  operand_in = 8'h00;
   logic        dec_done, dec_illegal, dec_index_iy, dec_wide;
   logic [1:0]  dec_kind;
   logic [2:0]  dec_reg;
   logic [23:0] dec_disp;
   logic [3:0]  dec_cycles;
   logic [7:0]  shift_out, flags_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sra_unit uut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
      .mode_long(mode_long), .operand_in(operand_in),
      .dec_done(dec_done), .dec_illegal(dec_illegal), .dec_kind(dec_kind),
      .dec_reg(dec_reg), .dec_index_iy(dec_index_iy), .dec_disp(dec_disp),
      .dec_wide(dec_wide), .dec_cycles(dec_cycles),
      .shift_out(shift_out), .flags_out(flags_out)
   );

   typedef struct packed {
      logic [2:0]  n;
      logic [39:0] bts;
      logic        mode;
      logic        ill;
      logic [1:0]  kind;
      logic [2:0]  rg;
      logic        iy;
      logic [7:0]  d8;
      logic        wide;
      logic [3:0]  cyc;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      // R3 register forms
      '{3'd2, 40'hCB28000000, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd2},
      '{3'd2, 40'hCB29000000, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 8'h00, 1'b1, 4'd2},
      '{3'd2, 40'hCB2A000000, 1'b0, 1'b0, 2'd0, 3'd2, 1'b0, 8'h00, 1'b0, 4'd2},
      '{3'd2, 40'hCB2B000000, 1'b1, 1'b0, 2'd0, 3'd3, 1'b0, 8'h00, 1'b1, 4'd2},
      '{3'd2, 40'hCB2C000000, 1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 8'h00, 1'b0, 4'd2},
      '{3'd2, 40'hCB2D000000, 1'b1, 1'b0, 2'd0, 3'd5, 1'b0, 8'h00, 1'b1, 4'd2},
      '{3'd2, 40'hCB2F000000, 1'b0, 1'b0, 2'd0, 3'd7, 1'b0, 8'h00, 1'b0, 4'd2},
      // R4 HL form
      '{3'd2, 40'hCB2E000000, 1'b1, 1'b0, 2'd1, 3'd6, 1'b0, 8'h00, 1'b1, 4'd5},
      // R5 override bytes on HL form
      '{3'd3, 40'h52CB2E0000, 1'b1, 1'b0, 2'd1, 3'd6, 1'b0, 8'h00, 1'b0, 4'd6},
      '{3'd3, 40'h49CB2E0000, 1'b0, 1'b0, 2'd1, 3'd6, 1'b0, 8'h00, 1'b1, 4'd6},
      // R6 indexed forms
      '{3'd4, 40'hDDCB052E00, 1'b0, 1'b0, 2'd2, 3'd6, 1'b0, 8'h05, 1'b0, 4'd7},
      '{3'd4, 40'hFDCB802E00, 1'b1, 1'b0, 2'd2, 3'd6, 1'b1, 8'h80, 1'b1, 4'd7},
      '{3'd5, 40'h52DDCB7F2E, 1'b1, 1'b0, 2'd2, 3'd6, 1'b0, 8'h7F, 1'b0, 4'd8},
      '{3'd5, 40'h49FDCBFF2E, 1'b0, 1'b0, 2'd2, 3'd6, 1'b1, 8'hFF, 1'b1, 4'd8},
      // R8 illegal sequences
      '{3'd3, 40'h52CB2F0000, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd3, 40'h49CB280000, 1'b1, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd4, 40'hDDCB102F00, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd2, 40'hDD2E000000, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd1, 40'h0000000000, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd2, 40'hCB3E000000, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      '{3'd2, 40'h5252000000, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 8'h00, 1'b0, 4'd0},
      // R8 recovery after the illegal run
      '{3'd2, 40'hCB2E000000, 1'b0, 1'b0, 2'd1, 3'd6, 1'b0, 8'h00, 1'b0, 4'd5}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_in    = b;
   endtask

   task automatic finish_seq;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic check_done(input string tag, input logic [1:0] kind, input logic [2:0] rg,
                             input logic iy, input logic [7:0] d8, input logic wide,
                             input logic [3:0] cyc);
      check(dec_done == 1'b1 && dec_illegal == 1'b0, {tag, " done"}, {dec_done, dec_illegal}, 2'b10);
      check(dec_kind == kind, {tag, " kind"}, dec_kind, kind);
      check(dec_reg == rg, {tag, " reg"}, dec_reg, rg);
      check(dec_index_iy == iy, {tag, " iy"}, dec_index_iy, iy);
      check(dec_disp == {{16{d8[7]}}, d8}, {tag, " disp"}, dec_disp, {{16{d8[7]}}, d8});
      check(dec_wide == wide, {tag, " wide"}, dec_wide, wide);
      check(dec_cycles == cyc, {tag, " cycles"}, dec_cycles, cyc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(dec_done == 1'b0 && dec_illegal == 1'b0, "R10 pulses low in reset", {dec_done, dec_illegal}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_done == 1'b0 && dec_illegal == 1'b0, "R10 pulses low after reset", {dec_done, dec_illegal}, 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string tag;
         v = VECS[i];
         mode_long = v.mode;
         tag = v.ill ? "R8" : (v.kind == 2'd0 ? "R3" : (v.kind == 2'd1 ? (v.cyc == 4'd6 ? "R5" : "R4") : "R6"));
         for (int k = 0; k < int'(v.n); k++) send(v.bts[39-8*k -: 8]);
         finish_seq();
         if (v.ill)
            check(dec_illegal == 1'b1 && dec_done == 1'b0, {tag, " illegal pulse"}, {dec_done, dec_illegal}, 2'b01);
         else
            check_done(tag, v.kind, v.rg, v.iy, v.d8, v.wide, v.cyc);
         @(negedge clk);
         check(dec_done == 1'b0 && dec_illegal == 1'b0, "R7 single-cycle pulse", {dec_done, dec_illegal}, 0);
      end

      // R9: gaps inside an indexed sequence
      mode_long = 1'b1;
      send(8'hDD); finish_seq(); repeat (3) @(negedge clk);
      check(dec_done == 1'b0 && dec_illegal == 1'b0, "R9 no pulse during gap", {dec_done, dec_illegal}, 0);
      send(8'hCB); finish_seq(); repeat (2) @(negedge clk);
      send(8'hF6); finish_seq(); @(negedge clk);
      send(8'h2E); finish_seq();
      check_done("R9", 2'd2, 3'd6, 1'b0, 8'hF6, 1'b1, 4'd7);

      // R10: reset drops a partial sequence
      send(8'hDD); send(8'hCB); finish_seq();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mode_long = 1'b0;
      send(8'hCB); send(8'h2B); finish_seq();
      check_done("R10", 2'd0, 3'd3, 1'b0, 8'h00, 1'b0, 4'd2);

      // R1 R2: all operand values
      for (int val = 0; val < 256; val++) begin
         logic [7:0] o, r, f;
         o = val[7:0];
         r = {o[7], o[7:1]};
         f = {r[7], (r == 8'h00), 1'b0, 1'b0, 1'b0, ~(^r), 1'b0, o[0]};
         @(negedge clk);
         operand_in = o;
         #1;
         check(shift_out == r, "R1 shift result", shift_out, r);
         check(flags_out == f, "R2 flag byte", flags_out, f);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule